// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register Bank

This block holds the 32-bit configuration space of a DRAM controller behind a 4 KiB window of aligned word registers. A protection word acts as a lock with three states: open, soft-locked and hard-locked. The state changes only when software writes a magic key to offset 0x000. A soft lock still lets software rewrite the protection word and reopen the bank. A hard lock freezes every protected register, including the protection word, until the next reset.

A small set of scratch and test registers accepts writes whatever the lock state is. Several registers change the written data before they store it, so that software always reads back a controller that is ready and passing. The configuration word reports a fixed hardware version and fixed read-only fields, and it carries the live RAM-size strap in its two low bits. Storage exists in two word windows: controller words at 0x000–0x0FC and PHY words at 0x400–0x5FC. Every other offset reads as zero.

Top module: `dram_cfg_regs`

## Requirements
- R1: Writing 0xFC600309 to offset 0x000, when the bank is not hard-locked, opens the bank. Offset 0x000 then reads 0x00000001, and writes to protected registers take effect.
- R2: Writing 0xDEADDEAD to offset 0x000, when the bank is not hard-locked, sets the hard lock, and offset 0x000 reads 0x00000010. Until reset, every write to a protected register, offset 0x000 included, is dropped.
- R3: Writing any other value to offset 0x000 while the bank is open or soft-locked gives the soft lock, and offset 0x000 reads 0x00000000. A later write of the opening key to offset 0x000 still opens the bank.
- R4: Offsets 0x050, 0x06C, 0x074, 0x078, 0x07C, 0x088, 0x08C and 0x0B4 store every write in every lock state.
- R5: While the bank is locked, a write to any other mapped offset leaves the register unchanged, and bus_err is high for the one cycle after the write.
- R6: Offset 0x004 reads as follows. Bits 31:28 are 3, bits 3:2 are 0b11 and bits 1:0 equal the current size_strap. Bits 19:14 and bit 6 read 0. All other bits hold the last accepted write.
- R7: A write accepted at offset 0x060 is stored with bit 0 cleared and bit 4 set.
- R8: A write accepted at offset 0x070 is stored with bit 12 set and bit 13 cleared.
- R9: An access to an offset outside 0x000–0x0FC and 0x400–0x5FC, or to an address that is not word-aligned, reads 0 and changes nothing. It raises bus_err for the one cycle after the access.
- R10: After reset the bank is soft-locked and offset 0x004 reads its forced fields. Offset 0x400 reads 0x2, offset 0x540 reads 0x0FFFFFFF, offsets 0x5A0 and 0x5F0 read 0xFF, and every other offset reads 0.
- R11: bus_rdata follows bus_addr combinationally. A read of the register being written in the same cycle returns the value it held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_strap | input | 2 | RAM-size strap, shown in configuration bits 1:0 |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | One-cycle pulse after an unmapped access or a dropped write |

## Verification
The assertions check three things on every cycle. The hard lock never leaves until reset. The stored configuration, status and test-control words never hold a forbidden bit. Every dropped or unmapped access is followed by an error pulse, and every error pulse has an access behind it. The bench sweeps every one of the 1024 word offsets, reading after reset and writing in the soft-locked, open and hard-locked states, and compares each result with a model of the register map. Only these scenarios show that a dropped write really left the old data in place, that the key sequences move between the lock states in the right order, and that the strap shows up live.

// File: rtl/dram_cfg_regs.sv
`timescale 1ns/1ps
module dram_cfg_regs #(
  parameter int ADDR_W     = 12,
  parameter int CTRL_WORDS = 64,
  parameter int PHY_BASE   = 256,
  parameter int PHY_WORDS  = 128,
  parameter int HW_VERSION = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        size_strap,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int TOTAL  = CTRL_WORDS + PHY_WORDS;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam logic [WORD_W-1:0] CTRL_END_W = WORD_W'(CTRL_WORDS);
  localparam logic [WORD_W-1:0] PHY_BASE_W = WORD_W'(PHY_BASE);
  localparam logic [WORD_W-1:0] PHY_END_W  = WORD_W'(PHY_BASE + PHY_WORDS);
  localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;
  localparam logic [31:0] RO_MASK  = 32'hF00F_C04F;
  localparam logic [31:0] FIXED    = {4'(HW_VERSION), 28'h000_000C};
  localparam int CONF_W = 1, STAT_W = 24, TEST_W = 28;
  localparam int PHY_STAT = CTRL_WORDS;
  localparam int PHY_EYE0 = CTRL_WORDS + 'h50;
  localparam int PHY_EYE1 = CTRL_WORDS + 'h68;
  localparam int PHY_EYE2 = CTRL_WORDS + 'h7C;

  typedef enum logic [1:0] {LK_SOFT = 2'd0, LK_OPEN = 2'd1, LK_HARD = 2'd2} lock_t;

  logic [31:0]       mem [TOTAL];
  lock_t             lock;
  logic [WORD_W-1:0] widx;
  logic [IDX_W-1:0]  idx;
  logic              ctrl_hit, phy_hit, mapped, white, blocked, wr_ok, err_d;
  logic [31:0]       wval, prot_val;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign ctrl_hit = widx < CTRL_END_W;
  assign phy_hit  = (widx >= PHY_BASE_W) && (widx < PHY_END_W);
  assign mapped   = (bus_addr[1:0] == 2'b00) && (ctrl_hit || phy_hit);
  assign idx      = ctrl_hit ? IDX_W'(widx) : IDX_W'(CTRL_WORDS) + IDX_W'(widx - PHY_BASE_W);
  assign white    = widx inside {WORD_W'('h14), WORD_W'('h1B), WORD_W'('h1D), WORD_W'('h1E),
                                 WORD_W'('h1F), WORD_W'('h22), WORD_W'('h23), WORD_W'('h2D)};
  assign blocked  = !white && ((lock == LK_HARD) || ((lock == LK_SOFT) && (widx != '0)));
  assign wr_ok    = bus_en && bus_we && mapped && !blocked;
  assign err_d    = bus_en && (!mapped || (bus_we && blocked));

  always_comb begin
    case (widx)
      WORD_W'(CONF_W): wval = bus_wdata & ~RO_MASK;
      WORD_W'(STAT_W): wval = (bus_wdata & ~32'h1) | 32'h10;
      WORD_W'(TEST_W): wval = (bus_wdata | 32'h1000) & ~32'h2000;
      default:         wval = bus_wdata;
    endcase
  end

  assign prot_val = (lock == LK_OPEN) ? 32'h1 : (lock == LK_HARD) ? 32'h10 : 32'h0;

  always_comb begin
    if (!mapped)                   bus_rdata = '0;
    else if (widx == '0)           bus_rdata = prot_val;
    else if (widx == WORD_W'(CONF_W)) bus_rdata = mem[CONF_W] | FIXED | {30'b0, size_strap};
    else                           bus_rdata = mem[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
      mem[PHY_STAT] <= 32'h2;
      mem[PHY_EYE0] <= 32'h0FFF_FFFF;
      mem[PHY_EYE1] <= 32'hFF;
      mem[PHY_EYE2] <= 32'hFF;
      lock    <= LK_SOFT;
      bus_err <= 1'b0;
    end else begin
      bus_err <= err_d;
      if (wr_ok) begin
        if (widx == '0)
          lock <= (bus_wdata == KEY_OPEN) ? LK_OPEN : (bus_wdata == KEY_HARD) ? LK_HARD : LK_SOFT;
        else
          mem[idx] <= wval;
      end
    end
  end

  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock == LK_HARD |=> lock == LK_HARD); // R2
  AST_LOCKED_DROP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && mapped && !white && lock != LK_OPEN && widx != '0) |=> bus_err); // R5
  AST_CONF_RO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[CONF_W] & RO_MASK) == 32'h0); // R6
  AST_STATUS_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem[STAT_W][0] == 1'b0); // R7
  AST_TEST_NO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    mem[TEST_W][13] == 1'b0); // R8
  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !mapped) |=> bus_err); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'h0); // R9
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_en)); // R9
endmodule

// File: tb/test_dram_cfg_regs.sv
`timescale 1ns/1ps
module test_dram_cfg_regs;
  localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;
  localparam logic [31:0] RO_MASK  = 32'hF00F_C04F;
  localparam logic [31:0] FIX      = 32'h3000_000C;

  logic clk = 0, rst_n = 0, en = 0, we = 0, err;
  logic [1:0] strap = 2'd2;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0;
  logic [31:0] m [1024];
  int lk;

  always #2.5 clk = ~clk;

  dram_cfg_regs i_dram_cfg_regs (.clk(clk), .rst_n(rst_n), .size_strap(strap), .bus_en(en),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err));

  function automatic bit mapped(int w);
    return (w < 64) || (w >= 256 && w < 384);
  endfunction
  function automatic bit white(int w);
    return w inside {20, 27, 29, 30, 31, 34, 35, 45};
  endfunction
  function automatic logic [31:0] xform(int w, logic [31:0] d);
    if (w == 1)  return d & ~RO_MASK;
    if (w == 24) return (d & ~32'h1) | 32'h10;
    if (w == 28) return (d | 32'h1000) & ~32'h2000;
    return d;
  endfunction
  function automatic logic [31:0] rexp(int w);
    if (!mapped(w)) return 0;
    if (w == 0) return (lk == 1) ? 32'h1 : (lk == 2) ? 32'h10 : 32'h0;
    if (w == 1) return m[1] | FIX | {30'b0, strap};
    return m[w];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int i = 0; i < 1024; i++) m[i] = 0;
    m[256] = 32'h2; m[256+'h50] = 32'h0FFF_FFFF; m[256+'h68] = 32'hFF; m[256+'h7C] = 32'hFF;
    lk = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; en = 0; we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    reset_model();
  endtask

  task automatic do_wr(int w, logic [31:0] d, string req);
    bit blk = mapped(w) && !white(w) && (lk == 2 || (lk == 0 && w != 0));
    bit e = !mapped(w) || blk;
    @(negedge clk); en = 1; we = 1; addr = 12'(w * 4); wdata = d;
    #1 chk("R11 old-on-write", rdata, rexp(w));
    @(negedge clk); en = 0; we = 0;
    chk({req, " err"}, {31'b0, err}, {31'b0, e});
    if (mapped(w) && !blk) begin
      if (w == 0) lk = (d == KEY_OPEN) ? 1 : (d == KEY_HARD) ? 2 : 0;
      else m[w] = xform(w, d);
    end
  endtask

  task automatic do_rd(int w, string req);
    @(negedge clk); en = 1; we = 0; addr = 12'(w * 4);
    #1 chk(req, rdata, rexp(w));
    @(negedge clk); en = 0;
    chk({req, " rd err"}, {31'b0, err}, {31'b0, !mapped(w)});
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R10 R9: full read sweep of reset state
    for (int w = 0; w < 1024; w++) do_rd(w, "R10");
    // R5 R4 R9: soft-locked write sweep, then readback
    for (int w = 1; w < 1024; w++) do_wr(w, 32'(w) * 32'h9E37_79B1 ^ 32'h5A5A_0000, "R5");
    for (int w = 0; w < 1024; w++) do_rd(w, "R4 R5 R9");
    // R1: open, then sweep with another pattern
    do_wr(0, KEY_OPEN, "R1");
    do_rd(0, "R1");
    for (int w = 1; w < 1024; w++) do_wr(w, ~(32'(w) * 32'h0101_0101), "R1");
    for (int w = 0; w < 1024; w++) do_rd(w, "R1 R6 R7 R8");
    // R6: all-ones and zeros into config, strap live
    do_wr(1, 32'hFFFF_FFFF, "R6"); do_rd(1, "R6");
    strap = 2'd1; #1 do_rd(1, "R6 strap");
    do_wr(1, 32'h0, "R6"); do_rd(1, "R6");
    strap = 2'd3; #1 do_rd(1, "R6 strap");
    // R7 R8
    do_wr(24, 32'hFFFF_FFFF, "R7"); do_rd(24, "R7");
    do_wr(24, 32'h0, "R7");         do_rd(24, "R7");
    do_wr(28, 32'hFFFF_FFFF, "R8"); do_rd(28, "R8");
    do_wr(28, 32'h0, "R8");         do_rd(28, "R8");
    // R3: soft lock, blocked write, reopen
    do_wr(0, 32'h1234_5678, "R3"); do_rd(0, "R3");
    do_wr(5, 32'hCAFE_0005, "R5"); do_rd(5, "R5");
    do_wr(0, KEY_OPEN, "R3");      do_rd(0, "R3");
    do_wr(5, 32'hCAFE_0005, "R1"); do_rd(5, "R1");
    // R2: hard lock is sticky
    do_wr(0, KEY_HARD, "R2");      do_rd(0, "R2");
    do_wr(0, KEY_OPEN, "R2");      do_rd(0, "R2");
    do_wr(0, 32'h0, "R2");         do_rd(0, "R2");
    do_wr(2, 32'h7777_0002, "R2"); do_rd(2, "R2");
    do_wr(256, 32'h1, "R2");       do_rd(256, "R2");
    do_wr(20, 32'h4444_0014, "R4"); do_rd(20, "R4");
    do_wr(45, 32'h4444_002D, "R4"); do_rd(45, "R4");
    // R9: misaligned access
    @(negedge clk); en = 1; we = 1; addr = 12'h052; wdata = 32'hFFFF_FFFF;
    #1 chk("R9 misaligned rd", rdata, 32'h0);
    @(negedge clk); en = 0; we = 0;
    chk("R9 misaligned err", {31'b0, err}, 32'h1);
    do_rd(20, "R9 misaligned no write");
    // R10: reset clears hard lock
    do_reset();
    for (int w = 0; w < 1024; w++) do_rd(w, "R10 after hard");
    do_wr(0, KEY_OPEN, "R10"); do_rd(0, "R10");
    summary();
    $finish;
  end
endmodule